// File: doc/BRIEF.md
# Byte-Drained Acceleration Sample Queue

This block holds up to 32 three-axis acceleration samples (X, Y and Z, 14 bits each) in arrival order. A sample source pushes one whole sample per clock. A host drains the queue one byte at a time through a single read strobe, and every byte comes from the oldest stored sample. A sample leaves the queue only once its last byte has been read. The byte sequence depends on a fast-read select. When it is set, each sample yields three bytes, the upper eight bits of X, then Y, then Z. When it is clear, each sample yields six bytes, each axis giving its upper byte first and then its lower byte, in the axis order X, Y, Z.

A two-bit mode input selects how the queue behaves. Off empties the queue and ignores pushes. Circular makes a push into a full queue discard the oldest sample. Stop makes a push into a full queue be dropped. In both full cases an overflow flag is raised. The block keeps a 6-bit count of stored samples and a watermark flag that compares this count against a programmable level. The host bus protocol and the sample producer lie outside this block.

Top module: `accel_sample_queue`

## Requirements
- R1: After a synchronous reset, count_o is 0, overflow_o is 0, watermark_o is 0 and rd_data_o is 0x00.
- R2: With fast_rd_i = 0, six successive byte reads of one sample return X[13:6], {X[5:0],2'b00}, Y[13:6], {Y[5:0],2'b00}, Z[13:6] and {Z[5:0],2'b00}, in that order.
- R3: With fast_rd_i = 1, three successive byte reads of one sample return X[13:6], Y[13:6] and Z[13:6], in that order.
- R4: count_o decrements by one only on the read of the last byte of a sample (byte 6 in the normal order, byte 3 in fast order), and the next read starts on the following sample.
- R5: A byte read while the queue is empty returns 0x00 and leaves count_o unchanged.
- R6: With mode_i = 2'b01 (circular), a push into a full queue (count 32) discards the oldest sample, keeps count_o at 32 and sets overflow_o.
- R7: With mode_i = 2'b10 or 2'b11 (stop), a push into a full queue is dropped, keeps count_o at 32, leaves the oldest sample in place and sets overflow_o.
- R8: overflow_o clears when a complete sample is removed by reading, or when mode_i is 2'b00.
- R9: watermark_o is 1 exactly when wmark_i is nonzero and count_o is at least wmark_i. It is updated on the same edge as count_o.
- R10: With mode_i = 2'b00 (off), the queue is emptied, pushes are ignored (count_o stays 0) and reads return 0x00.
- R11: rd_data_o changes only on a clock edge at which rd_i is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 off, 01 circular, 10/11 stop when full |
| fast_rd_i | input | 1 | 1 selects three upper bytes per sample |
| wmark_i | input | 6 | Watermark level, 0 disables the flag |
| push_i | input | 1 | Store one sample this cycle |
| smp_x_i | input | 14 | X sample value |
| smp_y_i | input | 14 | Y sample value |
| smp_z_i | input | 14 | Z sample value |
| rd_i | input | 1 | Byte read strobe |
| rd_data_o | output | 8 | Byte returned by the last read (registered) |
| count_o | output | 6 | Stored sample count |
| overflow_o | output | 1 | Push met a full queue |
| watermark_o | output | 1 | Count at or above the watermark |

## Verification
The byte path is driven with interleaved pushes and reads in both byte orders. Each sample uses distinct tag bytes per axis, so any swap of axis order, of upper and lower byte, or of sample order shows up as a wrong value. The bench fills the queue past capacity in circular mode and in both stop encodings, then reads the first byte. This tells discard-oldest apart from drop-newest and shows whether the overflow flag clears. Watermark crossings are checked in both directions, along with reads from an empty queue and a queue in off mode.

// File: rtl/asq_pkg.sv
package asq_pkg;
  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_CIRC = 2'b01;

  typedef logic [2:0] byte_idx_t;

  localparam byte_idx_t LAST_FAST = 3'd2;
  localparam byte_idx_t LAST_FULL = 3'd5;
endpackage

// File: rtl/asq_store.sv
module asq_store #(
  parameter int DEPTH = 32,
  parameter int W     = 42,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/asq_byte_pick.sv
module asq_byte_pick #(
  parameter int SW = 14,
  localparam int PAD = 16 - SW
) (
  input  logic [3*SW-1:0]      word,
  input  asq_pkg::byte_idx_t   idx,
  input  logic                 fast,
  output logic [7:0]           sel
);
  logic [7:0] hi [3];
  logic [7:0] lo [3];

  for (genvar a = 0; a < 3; a++) begin : g_axis
    assign hi[a] = word[a*SW + SW-1 -: 8];
    assign lo[a] = {word[a*SW +: SW-8], {PAD{1'b0}}};
  end

  always_comb begin
    sel = 8'h00;
    if (fast) begin
      case (idx)
        3'd0:    sel = hi[0];
        3'd1:    sel = hi[1];
        3'd2:    sel = hi[2];
        default: sel = 8'h00;
      endcase
    end else begin
      case (idx)
        3'd0:    sel = hi[0];
        3'd1:    sel = lo[0];
        3'd2:    sel = hi[1];
        3'd3:    sel = lo[1];
        3'd4:    sel = hi[2];
        3'd5:    sel = lo[2];
        default: sel = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/asq_ctrl.sv
module asq_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode_i,
  input  logic               fast_i,
  input  logic [CW-1:0]      wmark_i,
  input  logic               push_i,
  input  logic               rd_i,
  output logic               wr_en,
  output logic [AW-1:0]      wr_ptr,
  output logic [AW-1:0]      rd_ptr,
  output asq_pkg::byte_idx_t idx,
  output logic               rd_ok,
  output logic [CW-1:0]      cnt,
  output logic               ovf,
  output logic               wm
);
  import asq_pkg::*;

  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [CW-1:0] C1    = CW'(1);
  localparam logic [AW-1:0] P1    = AW'(1);

  logic      on, circ, full, empty, last, pop;
  logic      push_ok, drop_old, ovf_evt;
  logic [CW-1:0] cnt_n;

  assign on       = (mode_i != MODE_OFF);
  assign circ     = (mode_i == MODE_CIRC);
  assign full     = (cnt == FULLV);
  assign empty    = (cnt == '0);
  assign rd_ok    = rd_i && on && !empty;
  assign last     = fast_i ? (idx == LAST_FAST) : (idx == LAST_FULL);
  assign pop      = rd_ok && last;
  assign push_ok  = push_i && on && (!full || pop);
  assign ovf_evt  = push_i && on && full && !pop;
  assign drop_old = ovf_evt && circ;
  assign wr_en    = push_ok || drop_old;

  always_comb begin
    cnt_n = cnt;
    if (!on)                  cnt_n = '0;
    else if (push_ok && !pop) cnt_n = cnt + C1;
    else if (pop && !push_ok) cnt_n = cnt - C1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      idx    <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
      wm     <= 1'b0;
    end else begin
      cnt <= cnt_n;
      wm  <= (wmark_i != '0) && (cnt_n >= wmark_i);
      if (!on) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        idx    <= '0;
        ovf    <= 1'b0;
      end else begin
        if (wr_en) wr_ptr <= wr_ptr + P1;
        if (pop || drop_old) rd_ptr <= rd_ptr + P1;
        if (pop || drop_old) idx <= '0;
        else if (rd_ok)      idx <= idx + 3'd1;
        if (ovf_evt)  ovf <= 1'b1;
        else if (pop) ovf <= 1'b0;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULLV); // R6
  AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
    (pop && !push_ok) |=> (cnt == $past(cnt) - C1)); // R4
  AST_EMPTY_RD: assert property (@(posedge clk) disable iff (rst)
    (rd_i && empty && !push_i) |=> (cnt == '0)); // R5
  AST_CIRC_FULL: assert property (@(posedge clk) disable iff (rst)
    (circ && full && push_i && !pop) |=> (cnt == FULLV && ovf)); // R6
  AST_STOP_FULL: assert property (@(posedge clk) disable iff (rst)
    (on && !circ && full && push_i && !pop) |=> (cnt == FULLV && ovf && $stable(rd_ptr))); // R7
  AST_OVF_CLR: assert property (@(posedge clk) disable iff (rst)
    pop |=> !ovf); // R8
  AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_OFF) |=> (cnt == '0 && !ovf)); // R10
  AST_WM_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wm == ($past(wmark_i) != '0 && cnt >= $past(wmark_i)))); // R9
endmodule

// File: rtl/accel_sample_queue.sv
module accel_sample_queue #(
  parameter int DEPTH = 32,
  parameter int SW    = 14,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int WW   = 3 * SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_i,
  input  logic          fast_rd_i,
  input  logic [CW-1:0] wmark_i,
  input  logic          push_i,
  input  logic [SW-1:0] smp_x_i,
  input  logic [SW-1:0] smp_y_i,
  input  logic [SW-1:0] smp_z_i,
  input  logic          rd_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          overflow_o,
  output logic          watermark_o
);
  logic               wr_en, rd_ok;
  logic [AW-1:0]      wr_ptr, rd_ptr;
  asq_pkg::byte_idx_t idx;
  logic [WW-1:0]      rd_word;
  logic [7:0]         pick;

  asq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .fast_i(fast_rd_i),
    .wmark_i(wmark_i), .push_i(push_i), .rd_i(rd_i),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .idx(idx),
    .rd_ok(rd_ok), .cnt(count_o), .ovf(overflow_o), .wm(watermark_o)
  );

  asq_store #(.DEPTH(DEPTH), .W(WW)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_ptr),
    .wdata({smp_z_i, smp_y_i, smp_x_i}),
    .raddr(rd_ptr), .rdata(rd_word)
  );

  asq_byte_pick #(.SW(SW)) u_pick (
    .word(rd_word), .idx(idx), .fast(fast_rd_i), .sel(pick)
  );

  always_ff @(posedge clk) begin
    if (rst)       rd_data_o <= 8'h00;
    else if (rd_i) rd_data_o <= rd_ok ? pick : 8'h00;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o)); // R11
endmodule

// File: tb/accel_sample_queue_bench.sv
module accel_sample_queue_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b01;
  logic        fast = 1'b0;
  logic [5:0]  wmark = 6'd0;
  logic        push = 1'b0;
  logic [13:0] sx = '0, sy = '0, sz = '0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic [5:0]  count;
  logic        ovf, wm;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  accel_sample_queue u_accel_sample_queue (
    .clk(clk), .rst(rst), .mode_i(mode), .fast_rd_i(fast), .wmark_i(wmark),
    .push_i(push), .smp_x_i(sx), .smp_y_i(sy), .smp_z_i(sz), .rd_i(rd),
    .rd_data_o(rdata), .count_o(count), .overflow_o(ovf), .watermark_o(wm)
  );

  // vector: {is_read, fast, tag, expected byte, expected count}
  localparam int NV = 23;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0,1'b0,8'h10,8'h00,6'd1}, {1'b0,1'b0,8'h20,8'h00,6'd2},
    {1'b1,1'b0,8'h00,8'h10,6'd2}, {1'b1,1'b0,8'h00,8'h04,6'd2},
    {1'b1,1'b0,8'h00,8'h11,6'd2}, {1'b1,1'b0,8'h00,8'h08,6'd2},
    {1'b1,1'b0,8'h00,8'h12,6'd2}, {1'b1,1'b0,8'h00,8'h0C,6'd1},
    {1'b1,1'b0,8'h00,8'h20,6'd1}, {1'b1,1'b0,8'h00,8'h04,6'd1},
    {1'b1,1'b0,8'h00,8'h21,6'd1}, {1'b1,1'b0,8'h00,8'h08,6'd1},
    {1'b1,1'b0,8'h00,8'h22,6'd1}, {1'b1,1'b0,8'h00,8'h0C,6'd0},
    {1'b0,1'b1,8'h40,8'h00,6'd1}, {1'b0,1'b1,8'h50,8'h00,6'd2},
    {1'b1,1'b1,8'h00,8'h40,6'd2}, {1'b1,1'b1,8'h00,8'h41,6'd2},
    {1'b1,1'b1,8'h00,8'h42,6'd1}, {1'b1,1'b1,8'h00,8'h50,6'd1},
    {1'b1,1'b1,8'h00,8'h51,6'd1}, {1'b1,1'b1,8'h00,8'h52,6'd0},
    {1'b1,1'b1,8'h00,8'h00,6'd0}
  };

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
    end
  endtask

  task automatic do_push(input logic [7:0] t);
    @(negedge clk);
    push = 1'b1;
    sx = {t, 6'h01};
    sy = {t + 8'd1, 6'h02};
    sz = {t + 8'd2, 6'h03};
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic flush(input logic [1:0] m);
    @(negedge clk);
    mode = 2'b00;
    @(negedge clk);
    chk("R10 flush count", count, 0);
    chk("R8 overflow cleared by off", ovf, 0);
    mode = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset count", count, 0);
    chk("R1 reset overflow", ovf, 0);
    chk("R1 reset watermark", wm, 0);
    chk("R1 reset data", rdata, 0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      fast = VEC[v][22];
      if (VEC[v][23]) begin
        do_read();
        chk($sformatf("R2/R3/R5 byte vec %0d", v), rdata, int'(VEC[v][13:6]));
      end else begin
        do_push(VEC[v][21:14]);
      end
      chk($sformatf("R4/R5 count vec %0d", v), count, int'(VEC[v][5:0]));
    end

    // R11: data holds without a read strobe
    repeat (2) @(negedge clk);
    chk("R11 data held", rdata, 8'h00);
    do_push(8'h60);
    do_read();
    repeat (3) @(negedge clk);
    chk("R11 data held after read", rdata, 8'h60);

    // R9 watermark
    flush(2'b01);
    wmark = 6'd3;
    do_push(8'h04);
    do_push(8'h08);
    chk("R9 below watermark", wm, 0);
    do_push(8'h0C);
    chk("R9 at watermark", wm, 1);
    do_read(); do_read(); do_read();
    chk("R9 count after pop", count, 2);
    chk("R9 fell below watermark", wm, 0);
    wmark = 6'd0;

    // R6 circular overflow
    flush(2'b01);
    for (int k = 0; k < 32; k++) do_push(8'(k * 4));
    chk("R6 full count", count, 32);
    chk("R6 no overflow yet", ovf, 0);
    do_push(8'd128);
    chk("R6 count stays full", count, 32);
    chk("R6 overflow set", ovf, 1);
    do_read();
    chk("R6 oldest discarded", rdata, 8'h04);
    do_read(); do_read();
    chk("R8 overflow cleared by pop", ovf, 0);
    chk("R4 count after pop", count, 31);

    // R7 stop mode, both encodings
    for (int m = 2; m < 4; m++) begin
      flush(2'(m));
      for (int k = 0; k < 33; k++) do_push(8'(k * 4));
      chk($sformatf("R7 count full mode %0d", m), count, 32);
      chk($sformatf("R7 overflow mode %0d", m), ovf, 1);
      do_read();
      chk($sformatf("R7 oldest kept mode %0d", m), rdata, 8'h00);
      do_read();
      chk($sformatf("R7 second byte mode %0d", m), rdata, 8'h01);
    end

    // R10 off mode
    flush(2'b00);
    do_push(8'h70);
    chk("R10 push ignored", count, 0);
    do_read();
    chk("R10 read returns zero", rdata, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule